// File: doc/BRIEF.md
# Framed Serial Word Deserializer

This block takes a single serial data line together with the bit clock sent alongside it. It turns the line back into 12-bit parallel words. Each word travels in a 14-bit frame: a start bit of value 1, then twelve data bits with the least significant bit first, then a stop bit of value 0. The line may idle at 0 for any number of bit times between frames. Those filler bits are skipped, and the next 1 seen while searching is taken as the next start bit.

When a frame ends with a valid stop bit, the parallel word is updated and a word strobe drops low in the same clock. The strobe stays low for a fixed seven bit times, then rises again. The strobe therefore runs at the word rate, and it never pulses while no frame arrives. A direction input holds the receiver idle. A pair of mode inputs, when both are low, forces the parallel word and the strobe low at the outputs.

Top module: `word_deser`

## Requirements
- R1: A synchronous active-high reset sets the word output to 0 and the strobe high, and the receiver starts searching for a start bit.
- R2: A frame is a 1 start bit, twelve data bits with bit 0 sent first, and a 0 stop bit, all sampled on the rising bit-clock edge. The word output takes the twelve data bits at the edge that samples the stop bit, and it holds its value otherwise.
- R3: The strobe falls at the same clock edge at which the word output takes a new frame's data.
- R4: After it falls, the strobe stays low for exactly 7 bit clocks and is high from the 8th edge on.
- R5: While no valid frame completes, the strobe stays high and the word output does not change.
- R6: Any number of 0 filler bits between frames, including none, is ignored. The next 1 sampled while searching starts a frame.
- R7: A frame whose stop bit samples as 1 is discarded: there is no strobe pulse and the word is unchanged. The search for a start bit resumes with the next bit.
- R8: While the direction input is high, the receiver is held searching, any partial frame is abandoned, the word output is 0 and the strobe is high.
- R9: While both mode inputs are low, the word output and the strobe are 0 in the same cycle, and reception continues inside the block. Any other mode combination passes the internal values through.
- R10: A frame that carries the same data as the previous word still produces a full strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Forwarded bit clock; the line is sampled on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_i | input | 1 | Serial data line |
| dir_i | input | 1 | High holds the receiver idle; low enables deserializing |
| sel_a_i | input | 1 | Mode input A; low together with B forces the outputs low |
| sel_b_i | input | 1 | Mode input B; low together with A forces the outputs low |
| word_o | output | 12 | Parallel received word |
| strobe_o | output | 1 | Word strobe; falls on each new word and stays low 7 bit times |

## Verification
Frames are sent back to back and also with gaps of one, a few and many filler bits. These cases show whether the search restarts on the bit right after a stop bit and whether filler is really skipped. Alternating, all-ones, all-zeros and single-bit words expose an order reversal or a wrong bit position. A repeated word shows whether the strobe depends on the data changing. A bad stop bit, and a direction pulse raised mid-frame, show whether the receiver resynchronises on the correct later start bit. Forcing the mode pair low during a frame shows that the gating is only at the outputs.

// File: rtl/word_deser.sv
module word_deser #(
  parameter int DATA_W   = 12,
  parameter int LOW_BITS = 7
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ser_i,
  input  logic              dir_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  output logic [DATA_W-1:0] word_o,
  output logic              strobe_o
);
  localparam int BW = $clog2(DATA_W);
  localparam int CW = $clog2(LOW_BITS + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);
  localparam logic [CW-1:0] LOW_LOAD = CW'(LOW_BITS - 1);

  typedef enum logic [1:0] {HUNT, DATA, STOP} st_t;

  st_t              state;
  logic [BW-1:0]    bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] word_q;
  logic             strobe_q;
  logic [CW-1:0]    lo_cnt;
  logic             force_lo;

  always_ff @(posedge clk_i) begin
    if (rst_i || dir_i) begin
      state    <= HUNT;
      bit_cnt  <= '0;
      shreg    <= '0;
      word_q   <= '0;
      strobe_q <= 1'b1;
      lo_cnt   <= '0;
    end else begin
      if (!strobe_q) begin
        if (lo_cnt == '0) strobe_q <= 1'b1;
        else              lo_cnt   <= lo_cnt - 1'b1;
      end
      case (state)
        HUNT: if (ser_i) begin
          state   <= DATA;
          bit_cnt <= '0;
        end
        DATA: begin
          shreg <= {ser_i, shreg[DATA_W-1:1]};
          if (bit_cnt == LAST_BIT) state <= STOP;
          else bit_cnt <= bit_cnt + 1'b1;
        end
        STOP: begin
          state <= HUNT;
          if (!ser_i) begin
            word_q   <= shreg;
            strobe_q <= 1'b0;
            lo_cnt   <= LOW_LOAD;
          end
        end
        default: state <= HUNT;
      endcase
    end
  end

  assign force_lo = !sel_a_i && !sel_b_i;
  assign word_o   = force_lo ? '0 : word_q;
  assign strobe_o = !force_lo && strobe_q;

  // R3: a new word from the receiver always comes with a falling strobe
  a_r3_fall_with_word: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(word_q) && !$past(dir_i)) |-> $fell(strobe_q));

  // R4: the low phase ends once the counter is exhausted
  a_r4_low_ends: assert property (@(posedge clk_i) disable iff (rst_i)
    (!strobe_q && lo_cnt == '0) |=> strobe_q);

  // R7: a bad stop bit produces neither a strobe nor a new word
  a_r7_bad_stop: assert property (@(posedge clk_i) disable iff (rst_i || dir_i)
    (state == STOP && ser_i && strobe_q) |=> (strobe_q && $stable(word_q)));

  // R8: direction high leaves the receiver idle
  a_r8_dir_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    dir_i |=> (state == HUNT && strobe_q && word_q == '0));

endmodule

// File: tb/word_deser_tb.sv
`timescale 1ns/1ps
module word_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst_i = 1'b1, ser_i = 1'b0, dir_i = 1'b0;
  logic        sel_a_i = 1'b1, sel_b_i = 1'b1;
  logic [11:0] word_o;
  logic        strobe_o;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";

  int m_phase = -1, m_acc = 0, m_word = 0, m_low = 0;

  always #4 clk = ~clk;

  word_deser dut_i (.clk_i(clk), .rst_i(rst_i), .ser_i(ser_i), .dir_i(dir_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .word_o(word_o), .strobe_o(strobe_o));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update(input logic b);
    if (rst_i || dir_i) begin
      m_phase = -1; m_word = 0; m_low = 0;
    end else begin
      if (m_low > 0) m_low--;
      if (m_phase < 0) begin
        if (b) begin m_phase = 0; m_acc = 0; end
      end else if (m_phase < 12) begin
        if (b) m_acc = m_acc | (1 << m_phase);
        m_phase++;
      end else begin
        if (!b) begin m_word = m_acc; m_low = 7; end
        m_phase = -1;
      end
    end
  endtask

  task automatic compare();
    bit f = !sel_a_i && !sel_b_i;
    check({cur_req, " word"}, int'(word_o), f ? 0 : m_word);
    check({cur_req, " strobe"}, int'(strobe_o), f ? 0 : int'(m_low == 0));
  endtask

  task automatic step(input logic b);
    ser_i = b;
    @(posedge clk);
    model_update(b);
    @(negedge clk);
    compare();
  endtask

  task automatic frame(input logic [11:0] d, input logic stop_bit);
    step(1'b1);
    for (int i = 0; i < 12; i++) step(d[i]);
    step(stop_bit);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b0); step(1'b0);
    cur_req = "R1";
    check("R1 reset word", int'(word_o), 0);
    check("R1 reset strobe", int'(strobe_o), 1);
    rst_i = 1'b0;
    idle(3);

    cur_req = "R2";
    step(1'b1);
    for (int i = 0; i < 12; i++) step(12'hA5C >> i & 1);
    check("R2 word held before stop", int'(word_o), 0);
    step(1'b0);
    cur_req = "R3";
    check("R3 word at stop edge", int'(word_o), 'hA5C);
    check("R3 strobe low at stop edge", int'(strobe_o), 0);
    begin
      int n = 1;
      cur_req = "R4";
      while (!strobe_o && n < 20) begin step(1'b0); if (!strobe_o) n++; end
      check("R4 low length", n, 7);
    end
    idle(5);

    cur_req = "R6";
    frame(12'h001, 1'b0); frame(12'hFFF, 1'b0); frame(12'h800, 1'b0);
    idle(1); frame(12'h555, 1'b0); idle(3); frame(12'h000, 1'b0);
    idle(40); frame(12'hAAA, 1'b0);
    check("R6 last word", int'(word_o), 'hAAA);
    idle(10);

    cur_req = "R10";
    frame(12'h333, 1'b0); idle(10);
    frame(12'h333, 1'b0);
    check("R10 strobe low on repeat", int'(strobe_o), 0);
    idle(10);

    cur_req = "R7";
    frame(12'h777, 1'b1);
    check("R7 word unchanged", int'(word_o), 'h333);
    check("R7 no strobe", int'(strobe_o), 1);
    frame(12'h1E1, 1'b0);
    check("R7 next frame accepted", int'(word_o), 'h1E1);
    idle(10);

    cur_req = "R5";
    idle(30);
    check("R5 strobe stays high", int'(strobe_o), 1);

    cur_req = "R8";
    step(1'b1);
    for (int i = 0; i < 5; i++) step(1'b1);
    dir_i = 1'b1;
    step(1'b1); step(1'b0); step(1'b1);
    check("R8 word zero", int'(word_o), 0);
    check("R8 strobe high", int'(strobe_o), 1);
    dir_i = 1'b0;
    idle(20);
    frame(12'h6B2, 1'b0);
    check("R8 recovery word", int'(word_o), 'h6B2);
    idle(10);

    cur_req = "R9";
    sel_a_i = 1'b1; sel_b_i = 1'b0;
    frame(12'h0F0, 1'b0);
    check("R9 pass-through word", int'(word_o), 'h0F0);
    idle(10);
    sel_a_i = 1'b0;
    step(1'b1);
    for (int i = 0; i < 12; i++) step(12'h9C3 >> i & 1);
    step(1'b0);
    check("R9 forced word", int'(word_o), 0);
    check("R9 forced strobe", int'(strobe_o), 0);
    sel_a_i = 1'b1; sel_b_i = 1'b1;
    #1;
    check("R9 released word", int'(word_o), 'h9C3);
    check("R9 released strobe", int'(strobe_o), 0);
    idle(12);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule